// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block holds one horizontal line of display gray codes between the column data sampler and the digital-to-analog stage of a panel column driver. The sampler presents the whole assembled line on a wide parallel bus; when the line strobe rises, the block copies that bus into an internal line store and also samples the polarity input. The column outputs stay unchanged while the strobe is high. They take on the newly stored line only after the strobe falls.

Each column output carries a 6-bit gray code and a one-bit reference-bank select. The bank select tells the converter which reference set to use: the upper set (reference levels 0 to 4) or the lower set (levels 5 to 9). Neighbouring columns always use opposite sets. The captured polarity decides which column parity gets which set, so the panel can be driven with alternating drive polarity from line to line. The strobe is asynchronous to the system clock. It is synchronized and edge-detected inside the block.

Top module: `line_latch_steer`

## Requirements
- R1: While reset is asserted and after it is released, every column code is zero, and the bank selects follow the low-polarity pattern: 0 on odd columns and 1 on even columns.
- R2: On the strobe's rising edge the block captures the whole `line_data_in` bus and `pol_in`. Changes to either input after that capture, while the strobe is still high or between strobes, have no effect on the outputs.
- R3: While the strobe is high, every column code and bank select keeps the value it had before the strobe rose.
- R4: After the strobe falls, column c (counted from 1) outputs the captured bits `[6(c-1)+5 : 6(c-1)]`, with the lowest bit as the LSB, on `col_code_out` at the same bit positions.
- R5: With a captured polarity of 0, odd columns (1, 3, ...) select the upper bank (`bank_sel_out` bit = 0) and even columns select the lower bank (bit = 1).
- R6: With a captured polarity of 1, odd columns select the lower bank (bit = 1) and even columns select the upper bank (bit = 0).
- R7: Any two adjacent columns always carry opposite bank selects.
- R8: The outputs change exactly SYNC_STAGES+1 clock edges after the strobe falls (3 edges with the default of 2), and not before.
- R9: A strobe that is high for a single clock period is still honoured as a complete capture and update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | Line strobe, asynchronous; rising edge captures, falling edge updates |
| pol_in | input | 1 | Polarity, sampled on the strobe's rising edge |
| line_data_in | input | NUM_COLS*CODE_W (2880) | Full line from the sampler, column c in bits [6(c-1)+5:6(c-1)] |
| col_code_out | output | NUM_COLS*CODE_W (2880) | Gray code per column, same layout as the input |
| bank_sel_out | output | NUM_COLS (480) | Per-column reference bank: 0 upper (levels 0-4), 1 lower (levels 5-9) |

## Verification
The assertions check on every cycle that adjacent bank selects differ and that the outputs move only in the cycle after an internal falling-edge event. They also check that a rising-edge event loads the store from the input bus and that a falling-edge event copies the store and the captured polarity to the outputs. Other properties need the bench's scenarios: the exact edge count from the strobe falling to the update, that data and polarity changes after capture are ignored, that a one-cycle strobe still works, and the whole-line code mapping under random and directed data with both polarities.

// File: rtl/line_latch_pkg.sv
package line_latch_pkg;

    localparam int unsigned DEF_NUM_COLS    = 480;
    localparam int unsigned DEF_CODE_W      = 6;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Reference bank chosen for one column.
    typedef enum logic {
        BANK_UPPER = 1'b0,   // reference levels 0..4
        BANK_LOWER = 1'b1    // reference levels 5..9
    } bank_e;

    // Single-cycle strobe events in the clock domain.
    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_evt_t;

    // Zero-based index: odd_idx = 1 means an even column when counting from 1.
    function automatic bank_e bank_for(input logic pol, input logic odd_idx);
        return bank_e'(pol ^ odd_idx);
    endfunction

endpackage

// File: rtl/strobe_edge_detect.sv
module strobe_edge_detect
    import line_latch_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_async,
    output strobe_evt_t evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_prev_q;
    logic                   level;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= strobe_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) level_prev_q <= 1'b0;
        else     level_prev_q <= level;
    end

    always_comb begin
        evt.rise = level & ~level_prev_q;
        evt.fall = ~level & level_prev_q;
    end

endmodule

// File: rtl/line_store.sv
module line_store
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_COLS = DEF_NUM_COLS,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    localparam int unsigned LINE_W  = NUM_COLS * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LINE_W-1:0] line_in,
    input  logic              pol_in,
    output logic [LINE_W-1:0] line_q,
    output logic              pol_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            pol_q  <= 1'b0;
        end else if (capture) begin
            line_q <= line_in;
            pol_q  <= pol_in;
        end
    end

endmodule

// File: rtl/column_driver.sv
module column_driver
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_COLS = DEF_NUM_COLS,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    localparam int unsigned LINE_W  = NUM_COLS * CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                update,
    input  logic [LINE_W-1:0]   line_q,
    input  logic                pol_q,
    output logic [LINE_W-1:0]   code_out,
    output logic [NUM_COLS-1:0] bank_out
);

    generate
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            localparam logic ODD_IDX = logic'(c % 2);
            logic [CODE_W-1:0] code_q;
            bank_e             bank_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q <= '0;
                    bank_q <= bank_for(1'b0, ODD_IDX);
                end else if (update) begin
                    code_q <= line_q[c*CODE_W +: CODE_W];
                    bank_q <= bank_for(pol_q, ODD_IDX);
                end
            end

            assign code_out[c*CODE_W +: CODE_W] = code_q;
            assign bank_out[c]                  = logic'(bank_q);
        end
    endgenerate

endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_COLS    = DEF_NUM_COLS,
    parameter int unsigned CODE_W      = DEF_CODE_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned LINE_W     = NUM_COLS * CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_in,
    input  logic                pol_in,
    input  logic [LINE_W-1:0]   line_data_in,
    output logic [LINE_W-1:0]   col_code_out,
    output logic [NUM_COLS-1:0] bank_sel_out
);

    strobe_evt_t       evt;
    logic [LINE_W-1:0] line_q;
    logic              pol_q;

    strobe_edge_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (strobe_in),
        .evt          (evt)
    );

    line_store #(
        .NUM_COLS (NUM_COLS),
        .CODE_W   (CODE_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .capture (evt.rise),
        .line_in (line_data_in),
        .pol_in  (pol_in),
        .line_q  (line_q),
        .pol_q   (pol_q)
    );

    column_driver #(
        .NUM_COLS (NUM_COLS),
        .CODE_W   (CODE_W)
    ) u_drive (
        .clk      (clk),
        .rst      (rst),
        .update   (evt.fall),
        .line_q   (line_q),
        .pol_q    (pol_q),
        .code_out (col_code_out),
        .bank_out (bank_sel_out)
    );

endmodule

// File: rtl/line_latch_steer_chk.sv
module line_latch_steer_chk
    import line_latch_pkg::*;
#(
    parameter int unsigned NUM_COLS = DEF_NUM_COLS,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    localparam int unsigned LINE_W  = NUM_COLS * CODE_W
) (
    input logic                clk,
    input logic                rst,
    input strobe_evt_t         evt,
    input logic [LINE_W-1:0]   line_data_in,
    input logic                pol_in,
    input logic [LINE_W-1:0]   line_q,
    input logic                pol_q,
    input logic [LINE_W-1:0]   col_code_out,
    input logic [NUM_COLS-1:0] bank_sel_out
);

    logic adj_opposite;
    assign adj_opposite = &(bank_sel_out[NUM_COLS-1:1] ^ bank_sel_out[NUM_COLS-2:0]);

    // R7: neighbours always on opposite banks
    a_r7_adjacent_opposite: assert property (@(posedge clk) disable iff (rst)
        adj_opposite);

    // R1: reset clears codes and leaves column 1 on the upper bank
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (col_code_out == '0) && (bank_sel_out[0] == 1'b0));

    // R3: outputs move only after a falling-edge event
    a_r3_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(col_code_out) && $stable(bank_sel_out));

    // R2: a rising-edge event loads the line and polarity
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> (line_q == $past(line_data_in)) && (pol_q == $past(pol_in)));

    // R4: a falling-edge event drives the stored line to the columns
    a_r4_update_codes: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> col_code_out == $past(line_q));

    // R5 / R6: column 1 bank follows the captured polarity after update
    a_r5_bank_polarity: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> bank_sel_out[0] == $past(pol_q));

    // R2: the two edge events never coincide
    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt.rise && evt.fall));

endmodule

bind line_latch_steer line_latch_steer_chk #(
    .NUM_COLS (NUM_COLS),
    .CODE_W   (CODE_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .line_data_in (line_data_in),
    .pol_in       (pol_in),
    .line_q       (line_q),
    .pol_q        (pol_q),
    .col_code_out (col_code_out),
    .bank_sel_out (bank_sel_out)
);

// File: tb/line_latch_steer_test.sv
`timescale 1ns/1ps
module line_latch_steer_test;

    localparam int NC     = 480;
    localparam int CW     = 6;
    localparam int SYNC   = 2;
    localparam int LW     = NC * CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_in = 1'b0;
    logic          pol_in = 1'b0;
    logic [LW-1:0] line_data_in = '0;
    logic [LW-1:0] col_code_out;
    logic [NC-1:0] bank_sel_out;

    int checks = 0;
    int errors = 0;

    logic [LW-1:0] exp_code = '0;
    logic          exp_pol  = 1'b0;

    always #5 clk = ~clk;

    line_latch_steer #(.NUM_COLS(NC), .CODE_W(CW), .SYNC_STAGES(SYNC)) uut (
        .clk          (clk),
        .rst          (rst),
        .strobe_in    (strobe_in),
        .pol_in       (pol_in),
        .line_data_in (line_data_in),
        .col_code_out (col_code_out),
        .bank_sel_out (bank_sel_out)
    );

    function automatic logic [NC-1:0] bank_pattern(input logic pol);
        logic [NC-1:0] p;
        for (int c = 0; c < NC; c++) p[c] = pol ^ c[0];   // col 1 = index 0 = odd column
        return p;
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] d;
        for (int c = 0; c < NC; c++) d[c*CW +: CW] = CW'($urandom_range(0, 63));
        return d;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        logic [NC-1:0] eb;
        eb = bank_pattern(exp_pol);
        checks++;
        if (col_code_out !== exp_code) begin
            errors++;
            for (int c = 0; c < NC; c++) begin
                if (col_code_out[c*CW +: CW] !== exp_code[c*CW +: CW]) begin
                    $display("FAIL %s col %0d code actual %0d expected %0d", tag, c+1,
                             col_code_out[c*CW +: CW], exp_code[c*CW +: CW]);
                    break;
                end
            end
        end
        checks++;
        if (bank_sel_out !== eb) begin
            errors++;
            $display("FAIL %s bank actual %h expected %h", tag, bank_sel_out, eb);
        end
    endtask

    // Drive one line; optionally scramble inputs after capture (R2).
    task automatic drive_line(input logic [LW-1:0] d, input logic p,
                              input int high_cycles, input bit scramble);
        line_data_in = d;
        pol_in       = p;
        strobe_in    = 1'b1;
        if (scramble) begin
            step(SYNC + 2);
            line_data_in = rand_line();
            pol_in       = ~p;
            step(high_cycles - SYNC - 2);
        end else begin
            step(high_cycles);
        end
        check_outputs("R3 hold while strobe high");
        strobe_in = 1'b0;
        step(SYNC);
        check_outputs("R8 no update before latency");
        step(1);
        exp_code = d;
        exp_pol  = p;
        check_outputs(scramble ? "R2 R4 captured line after late input change" : "R4 R8 line update");
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [LW-1:0] d;
        int unsigned seed_val;
        seed_val = $urandom(32'h5eed_1234);
        step(1);
        check_outputs("R1 during reset");
        step(4);
        rst = 1'b0;
        step(2);
        check_outputs("R1 after reset");

        // R5 all-ones line, low polarity
        d = '1;
        drive_line(d, 1'b0, 6, 1'b0);
        check_outputs("R5 low polarity banks");

        // R6 ramp line, high polarity; R7 adjacency through pattern check
        for (int c = 0; c < NC; c++) d[c*CW +: CW] = CW'(c);
        drive_line(d, 1'b1, 6, 1'b0);
        check_outputs("R6 R7 high polarity banks");

        // R2 inputs change between strobes: no effect
        line_data_in = rand_line();
        pol_in       = 1'b0;
        step(10);
        check_outputs("R2 idle input change ignored");

        // R2 scramble after capture
        drive_line(rand_line(), 1'b0, 8, 1'b1);
        drive_line(rand_line(), 1'b1, 9, 1'b1);

        // R9 single-cycle strobe
        drive_line(rand_line(), 1'b0, 1, 1'b0);
        check_outputs("R9 single cycle strobe");
        drive_line('0, 1'b1, 1, 1'b0);
        check_outputs("R9 zero line single cycle strobe");

        // Random lines with random polarity and strobe width
        for (int i = 0; i < 20; i++) begin
            drive_line(rand_line(), 1'($urandom_range(0, 1)),
                       int'($urandom_range(5, 12)), 1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule